// File: doc/BRIEF.md
# Packet Header Stripper and Channel Router

This block sits between a host byte-stream front end and two DMA write ports. Input bytes arrive over a valid/ready handshake. Each packet opens with a four-byte header: a start marker, a channel code, and a 16-bit payload length. The block checks the marker and decodes the channel. It loads the length, then passes exactly that many payload bytes to either the command port or the image port. It never forwards header bytes. It needs no help from a processor.

A state machine with five named states does the parsing:

| State | Role |
|-------|------|
| `ST_HUNT` | Waits for the start marker and discards any other byte. |
| `ST_CHAN` | Decodes the channel code. |
| `ST_LEN_HI` | Takes the high length byte. |
| `ST_LEN_LO` | Takes the low length byte. |
| `ST_BODY` | Forwards the payload. |

The state machine uses these named transitions:

| Transition | Path | Taken when |
|------------|------|------------|
| `T_MARK_OK` | `ST_HUNT`→`ST_CHAN` | The start marker matches. |
| `T_MARK_BAD` | `ST_HUNT`→`ST_HUNT` | Any other byte arrives; the error flag is set. |
| `T_CHAN_OK` | `ST_CHAN`→`ST_LEN_HI` | The channel code is known. |
| `T_CHAN_BAD` | `ST_CHAN`→`ST_HUNT` | The channel code is unknown; the error flag is set. |
| `T_LEN_HI` | `ST_LEN_HI`→`ST_LEN_LO` | Always. |
| `T_LEN_EMPTY` | `ST_LEN_LO`→`ST_HUNT` | The length is zero. |
| `T_LEN_BODY` | `ST_LEN_LO`→`ST_BODY` | The length is non-zero. |
| `T_BODY_END` | `ST_BODY`→`ST_HUNT` | The last payload byte is taken. |

The marker value and both channel codes come from configuration inputs. The payload path is combinational, so back-pressure from the selected port reaches the input ready directly. No byte is stored inside the block, and none is lost.

Top module: `pkt_router`

## Requirements
- R1: After reset the parser is in `ST_HUNT`. `in_ready` is 1, both output valids are 0 and `err_flags` is 2'b00.
- R2: Header bytes are consumed with `in_ready` high and never appear as a valid output byte. Only payload bytes are forwarded, with `*_data` equal to `in_data`.
- R3: A channel byte equal to `cfg_cmd_code` routes the payload to the command port. One equal to `cfg_img_code` routes it to the image port. The two output valids are never high together.
- R4: The length field is sent high byte first. Exactly that many payload bytes are forwarded, and the byte after the last one is parsed as a new start marker.
- R5: A length of zero forwards nothing, and the very next byte is parsed as a start marker.
- R6: In `ST_HUNT`, a byte that differs from `cfg_sop` is discarded and sets `err_flags[0]`. Bytes keep being discarded until a matching marker arrives.
- R7: A channel byte that matches neither code sets `err_flags[1]` and returns the parser to `ST_HUNT`.
- R8: Once set, each bit of `err_flags` stays set until reset.
- R9: During the payload, `in_ready` follows the ready of the selected port, and the other port's ready has no effect. While stalled, the selected valid stays high with the same data, and no byte is lost or repeated.
- R10: The marker and channel codes are taken from the configuration inputs. If both channel codes are equal, the command port wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sop | input | 8 | Expected start marker value |
| cfg_cmd_code | input | 8 | Channel code for command packets |
| cfg_img_code | input | 8 | Channel code for image packets |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Block accepts the byte this cycle |
| cmd_data | output | 8 | Payload byte to command DMA |
| cmd_valid | output | 1 | Command byte present |
| cmd_ready | input | 1 | Command DMA accepts |
| img_data | output | 8 | Payload byte to image DMA |
| img_valid | output | 1 | Image byte present |
| img_ready | input | 1 | Image DMA accepts |
| err_flags | output | 2 | Sticky errors: bit 0 bad marker, bit 1 unknown channel |

## Verification
The bench builds the block with its default `DATA_W` of 8, which gives a 16-bit length field. At that width, a 259-byte packet with length 0x0103 puts a non-zero value in the high length byte. If the byte order were swapped, a later packet would be misparsed, so that case exposes the fault. Random packets run with randomly toggled readies on both ports. Together with zero-length packets, this covers back-pressure in every state and the `T_LEN_EMPTY` path.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CHAN,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_BODY
    } rx_state_t;

    typedef enum logic {
        DEST_CMD,
        DEST_IMG
    } dest_t;
endpackage

// File: rtl/pkt_len_counter.sv
module pkt_len_counter #(
    parameter int DATA_W = 8,
    localparam int LEN_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              beat,
    output logic              len_is_zero,
    output logic              last_beat
);
    logic [DATA_W-1:0] hi_q;
    logic [LEN_W-1:0]  remain_q;

    // Length assembled from the held high byte and the low byte now on the bus
    assign len_is_zero = ({hi_q, byte_in} == '0);
    assign last_beat   = (remain_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            remain_q <= '0;
        end else begin
            if (load_hi) hi_q <= byte_in;
            if (load_lo) remain_q <= {hi_q, byte_in};
            else if (beat) remain_q <= remain_q - LEN_W'(1);
        end
    end
endmodule

// File: rtl/pkt_hdr_fsm.sv
module pkt_hdr_fsm
    import pkt_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              take,
    input  logic [DATA_W-1:0] cfg_sop,
    input  logic [DATA_W-1:0] cfg_cmd_code,
    input  logic [DATA_W-1:0] cfg_img_code,
    input  logic              len_is_zero,
    input  logic              last_beat,
    output rx_state_t         state,
    output dest_t             dest,
    output logic              load_hi,
    output logic              load_lo,
    output logic              beat,
    output logic [1:0]        err_flags
);
    rx_state_t state_d;
    dest_t     dest_d;
    logic      set_sop_err;
    logic      set_chan_err;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_HUNT:   if (take && byte_in == cfg_sop) state_d = ST_CHAN;          // T_MARK_OK
            ST_CHAN:   if (take) begin
                           if (byte_in == cfg_cmd_code || byte_in == cfg_img_code)
                               state_d = ST_LEN_HI;                                // T_CHAN_OK
                           else
                               state_d = ST_HUNT;                                  // T_CHAN_BAD
                       end
            ST_LEN_HI: if (take) state_d = ST_LEN_LO;                              // T_LEN_HI
            ST_LEN_LO: if (take) state_d = len_is_zero ? ST_HUNT : ST_BODY;        // T_LEN_EMPTY / T_LEN_BODY
            ST_BODY:   if (take && last_beat) state_d = ST_HUNT;                   // T_BODY_END
            default:   state_d = ST_HUNT;
        endcase
    end

    // Outputs of the machine
    always_comb begin
        load_hi      = 1'b0;
        load_lo      = 1'b0;
        beat         = 1'b0;
        set_sop_err  = 1'b0;
        set_chan_err = 1'b0;
        dest_d       = dest;
        unique case (state)
            ST_HUNT:   set_sop_err = take && (byte_in != cfg_sop);                 // T_MARK_BAD
            ST_CHAN:   if (take) begin
                           if (byte_in == cfg_cmd_code)      dest_d = DEST_CMD;    // command wins ties
                           else if (byte_in == cfg_img_code) dest_d = DEST_IMG;
                           else                              set_chan_err = 1'b1;
                       end
            ST_LEN_HI: load_hi = take;
            ST_LEN_LO: load_lo = take;
            ST_BODY:   beat    = take;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest      <= DEST_CMD;
            err_flags <= 2'b00;
        end else begin
            dest      <= dest_d;
            err_flags <= err_flags | {set_chan_err, set_sop_err};
        end
    end
endmodule

// File: rtl/pkt_steer.sv
module pkt_steer
    import pkt_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              body,
    input  dest_t             dest,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              cmd_ready,
    input  logic              img_ready,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] img_data,
    output logic              img_valid,
    output logic              sel_ready
);
    assign cmd_data  = in_data;
    assign img_data  = in_data;
    assign cmd_valid = body && in_valid && (dest == DEST_CMD);
    assign img_valid = body && in_valid && (dest == DEST_IMG);
    assign sel_ready = (dest == DEST_CMD) ? cmd_ready : img_ready;
endmodule

// File: rtl/pkt_router.sv
module pkt_router
    import pkt_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cfg_sop,
    input  logic [DATA_W-1:0] cfg_cmd_code,
    input  logic [DATA_W-1:0] cfg_img_code,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] img_data,
    output logic              img_valid,
    input  logic              img_ready,
    output logic [1:0]        err_flags
);
    rx_state_t state;
    dest_t     dest;
    logic      body, sel_ready, take;
    logic      load_hi, load_lo, beat, len_is_zero, last_beat;

    assign body     = (state == ST_BODY);
    assign in_ready = body ? sel_ready : 1'b1;
    assign take     = in_valid && in_ready;

    pkt_hdr_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk, .rst_n, .byte_in(in_data), .take,
        .cfg_sop, .cfg_cmd_code, .cfg_img_code,
        .len_is_zero, .last_beat,
        .state, .dest, .load_hi, .load_lo, .beat, .err_flags
    );

    pkt_len_counter #(.DATA_W(DATA_W)) u_len (
        .clk, .rst_n, .byte_in(in_data),
        .load_hi, .load_lo, .beat,
        .len_is_zero, .last_beat
    );

    pkt_steer #(.DATA_W(DATA_W)) u_steer (
        .body, .dest, .in_data, .in_valid,
        .cmd_ready, .img_ready,
        .cmd_data, .cmd_valid, .img_data, .img_valid, .sel_ready
    );
endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] cmd_data,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [DATA_W-1:0] img_data,
    input logic              img_valid,
    input logic              img_ready,
    input logic [1:0]        err_flags
);
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && img_valid)); // R3

    AST_OUT_FROM_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || img_valid) |-> in_valid); // R2

    AST_CMD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_data == in_data)); // R2

    AST_IMG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        img_valid |-> (img_data == in_data)); // R2

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |->
            ((cmd_valid && !cmd_ready) || (img_valid && !img_ready))); // R9

    AST_SOP_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[0] |=> err_flags[0]); // R8

    AST_CHAN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[1] |=> err_flags[1]); // R8
endmodule

bind pkt_router pkt_router_chk #(.DATA_W(DATA_W)) u_chk (
    .clk, .rst_n, .in_data, .in_valid, .in_ready,
    .cmd_data, .cmd_valid, .cmd_ready,
    .img_data, .img_valid, .img_ready, .err_flags
);

// File: tb/pkt_router_test.sv
module pkt_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_sop = 8'hA5, cfg_cmd_code = 8'h01, cfg_img_code = 8'h02;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_ready;
    logic [7:0] cmd_data, img_data;
    logic       cmd_valid, img_valid;
    logic       cmd_ready = 1'b1, img_ready = 1'b1;
    logic [1:0] err_flags;

    int n_chk = 0, n_fail = 0;
    int rdy_mode = 0;               // 0 all ready, 1 random
    logic [7:0] q_cmd[$];
    logic [7:0] q_img[$];

    always #2 clk = ~clk;           // 250 MHz

    pkt_router uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit pick_ready();
        return (rdy_mode == 0) ? 1'b1 : ($urandom % 4 != 0);
    endfunction

    // Sampled after inputs settle, before the next rising edge: a transfer happens there
    task automatic observe();
        if (cmd_valid && cmd_ready) begin
            if (q_cmd.size() == 0) chk("R2", cmd_data, 32'hFFFF, "unexpected command byte");
            else chk("R3", cmd_data, q_cmd.pop_front(), "command payload");
        end
        if (img_valid && img_ready) begin
            if (q_img.size() == 0) chk("R2", img_data, 32'hFFFF, "unexpected image byte");
            else chk("R3", img_data, q_img.pop_front(), "image payload");
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            cmd_ready = pick_ready();
            img_ready = pick_ready();
            in_valid = 1'b1;
            in_data  = b;
            #1;
            observe();
            done = in_ready;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_ready = pick_ready();
            img_ready = pick_ready();
            in_valid = 1'b0;
            #1;
            observe();
        end
    endtask

    // dest: 0 command, 1 image, 2 none expected
    task automatic send_pkt(input logic [7:0] code, input int len, input int dest);
        send_byte(cfg_sop);
        send_byte(code);
        send_byte(8'(len >> 8));
        send_byte(8'(len));
        for (int i = 0; i < len; i++) begin
            logic [7:0] p = 8'($urandom);
            if (dest == 0) q_cmd.push_back(p);
            else if (dest == 1) q_img.push_back(p);
            send_byte(p);
        end
    endtask

    task automatic drained(string req);
        chk(req, q_cmd.size(), 0, "command bytes missing");
        chk(req, q_img.size(), 0, "image bytes missing");
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", in_ready, 1, "in_ready after reset");
        chk("R1", {cmd_valid, img_valid}, 0, "valids after reset");
        chk("R1", err_flags, 0, "err_flags after reset");

        // R2/R3 basic command then image
        send_pkt(cfg_cmd_code, 5, 0);
        send_pkt(cfg_img_code, 7, 1);
        idle(2);
        drained("R3");
        chk("R2", err_flags, 0, "no error on clean packets");

        // R4 long packet with non-zero high length byte, then a follow-up packet
        send_pkt(cfg_cmd_code, 259, 0);
        send_pkt(cfg_img_code, 3, 1);
        idle(2);
        drained("R4");

        // R5 zero length packets back to back
        send_pkt(cfg_img_code, 0, 1);
        send_pkt(cfg_cmd_code, 0, 0);
        send_pkt(cfg_cmd_code, 2, 0);
        idle(2);
        drained("R5");
        chk("R5", err_flags, 0, "zero length raises no error");

        // R9 stall on selected port, other port's ready irrelevant
        begin
            logic [7:0] p = 8'h3C;
            send_byte(cfg_sop); send_byte(cfg_cmd_code); send_byte(8'h00); send_byte(8'h01);
            q_cmd.push_back(p);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                cmd_ready = 1'b0; img_ready = 1'b1;
                in_valid = 1'b1; in_data = p;
                #1;
                chk("R9", in_ready, 0, "in_ready under stall");
                chk("R9", {cmd_valid, cmd_data}, {1'b1, p}, "held command byte");
            end
            send_byte(p);
            idle(2);
            drained("R9");
        end

        // R6 bad start bytes discarded, sticky flag
        send_byte(8'h11);
        send_byte(8'h22);
        idle(1);
        chk("R6", err_flags, 2'b01, "bad marker flag");
        send_pkt(cfg_img_code, 4, 1);
        idle(2);
        drained("R6");

        // R7 unknown channel then recovery
        send_byte(cfg_sop);
        send_byte(8'h7E);
        idle(1);
        chk("R7", err_flags, 2'b11, "unknown channel flag");
        send_pkt(cfg_cmd_code, 4, 0);
        idle(2);
        drained("R7");
        chk("R8", err_flags, 2'b11, "flags stay set");

        // R10 programmable marker and codes, tie goes to command
        cfg_sop = 8'h5A; cfg_cmd_code = 8'h40; cfg_img_code = 8'h41;
        send_pkt(8'h41, 6, 1);
        send_pkt(8'h40, 6, 0);
        cfg_img_code = 8'h40;
        send_pkt(8'h40, 5, 0);
        idle(2);
        drained("R10");
        cfg_sop = 8'hA5; cfg_cmd_code = 8'h01; cfg_img_code = 8'h02;

        // Random traffic with random back-pressure
        rdy_mode = 1;
        for (int k = 0; k < 40; k++) begin
            int d = $urandom % 2;
            send_pkt(d ? cfg_img_code : cfg_cmd_code, $urandom % 41, d);
            if ($urandom % 3 == 0) idle($urandom % 3);
        end
        rdy_mode = 0;
        idle(3);
        drained("R9");
        chk("R8", err_flags, 2'b11, "flags still set at end");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule